// File: doc/BRIEF.md
# LED Display Controller Command Sequencer

This block decides which register writes a serial LED display controller receives and in what order. It sits above a 16-bit command shifter and hands it one address byte and one data byte at a time, over a start/busy handshake. After reset it brings the controller up. It blanks the display, selects raw segment mode (no font decoding), enables all eight digit or row lines, sets the brightness, clears the eight digit registers and then turns the display on.

Later, a refresh request rewrites all eight digit registers from an eight-byte frame. The frame is captured when the request is accepted. The rewrite happens while the display is blanked, and the display is turned back on at the end. Requests that arrive while a sequence is running wait until the sequencer is idle. A build-time option adds single writes that switch the controller's all-LEDs-on test mode on and off.

Top module: `disp_cmd_sequencer`

## Requirements
- R1: While reset is asserted, cmd_start stays low. The first write after reset is address 0x0C with data 0x00, which blanks the display.
- R2: The initialization continues with these writes, in order: address 0x09 with data 0x00 (raw mode), address 0x0B with data 0x07 (all eight lines scanned), and address 0x0A with data equal to intensity_in zero-extended to eight bits.
- R3: Initialization then writes digit addresses 0x01 through 0x08 in ascending order, each with data 0x00. It ends with address 0x0C and data 0x01. Initialization is exactly 13 writes.
- R4: An accepted refresh performs exactly 10 writes. The first is 0x0C with data 0x00. Then, for i = 0 to 7, address i+1 receives frame_in bits [8i+7:8i]. The last is 0x0C with data 0x01.
- R5: The frame is sampled in the cycle the refresh is accepted. Changes to frame_in after that cycle do not alter the bytes written by that refresh.
- R6: A refresh request that arrives during initialization or during a refresh is serviced after the running sequence ends. Any number of requests during one sequence produce exactly one further refresh.
- R7: cmd_start is high for exactly one cycle per write, and cmd_addr and cmd_data are valid while it is high. A new cmd_start never occurs while cmd_busy is high. The next write begins only after cmd_busy has risen and then fallen.
- R8: With ENABLE_TEST=1, test_on_req causes one write of address 0x0F with data 0x01, and test_off_req causes one write of address 0x0F with data 0x00.
- R9: With ENABLE_TEST=0, test_on_req and test_off_req have no effect, and no write to address 0x0F ever occurs.
- R10: When several requests are pending at idle, a refresh is served first, then test-on, then test-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_req | input | 1 | One-cycle request to rewrite the digit registers |
| frame_in | input | NUM_DIGITS*DATA_W | Display bytes; byte i (bits [8i+7:8i]) goes to digit i |
| intensity_in | input | INT_W | Brightness level used during initialization |
| test_on_req | input | 1 | One-cycle request to enter the all-LEDs-on test mode |
| test_off_req | input | 1 | One-cycle request to leave the test mode |
| cmd_busy | input | 1 | High while the shifter is sending a command |
| cmd_start | output | 1 | One-cycle pulse that starts one command |
| cmd_addr | output | 8 | Register address of the command |
| cmd_data | output | DATA_W | Data byte of the command |

## Verification
On every cycle, the assertions check the handshake rules: start is a single-cycle pulse, it never overlaps a running shift, and it never occurs while the sequencer is idle. They also check that every digit write carries address index+1 and the buffered byte, that the closing write always turns the display on, and that no test-mode write appears when the option is off. Only the bench scenarios can show the whole write order of initialization and refresh, the frame capture at acceptance, the merging of pending requests, and the priority among queued requests. The bench checks these by recording every command a shifter model accepts.

// File: rtl/disp_seq_pkg.sv
// Shared step and state encodings plus register addresses for the display
// command sequencer. Assumes an 8-bit register address on the shifter side.
package disp_seq_pkg;

    typedef enum logic [2:0] {
        ST_BLANK,
        ST_DECODE,
        ST_SCAN,
        ST_BRIGHT,
        ST_DIGIT,
        ST_UNBLANK,
        ST_TEST_ON,
        ST_TEST_OFF
    } step_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_RISE,
        WP_FALL
    } port_state_t;

    localparam logic [7:0] A_DECODE = 8'h09;
    localparam logic [7:0] A_BRIGHT = 8'h0A;
    localparam logic [7:0] A_SCAN   = 8'h0B;
    localparam logic [7:0] A_SHUT   = 8'h0C;
    localparam logic [7:0] A_TEST   = 8'h0F;

endpackage

// File: rtl/disp_step_decode.sv
// Maps the current sequencer step to the register address and data byte of
// the write. Purely combinational; assumes digit < NUM_DIGITS.
module disp_step_decode
    import disp_seq_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int DATA_W     = 8,
    parameter int INT_W      = 4,
    localparam int DIG_W     = $clog2(NUM_DIGITS),
    localparam int FRAME_W   = NUM_DIGITS * DATA_W
) (
    input  step_t               step,
    input  logic [DIG_W-1:0]    digit,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [INT_W-1:0]    bright,
    output logic [7:0]          addr,
    output logic [DATA_W-1:0]   data
);

    // Select address and payload for the step being issued.
    always_comb begin
        addr = A_SHUT;
        data = '0;
        case (step)
            ST_BLANK:    begin addr = A_SHUT;   data = '0; end
            ST_DECODE:   begin addr = A_DECODE; data = '0; end
            ST_SCAN:     begin addr = A_SCAN;   data = DATA_W'(NUM_DIGITS - 1); end
            ST_BRIGHT:   begin addr = A_BRIGHT; data = DATA_W'(bright); end
            ST_DIGIT:    begin addr = 8'(digit) + 8'd1; data = frame[digit*DATA_W +: DATA_W]; end
            ST_UNBLANK:  begin addr = A_SHUT;   data = DATA_W'(1); end
            ST_TEST_ON:  begin addr = A_TEST;   data = DATA_W'(1); end
            ST_TEST_OFF: begin addr = A_TEST;   data = '0; end
            default:     begin addr = A_SHUT;   data = '0; end
        endcase
    end

endmodule

// File: rtl/disp_write_port.sv
// Start/busy handshake toward the serial shifter. On go it latches the
// command and pulses start for one cycle. It then waits for busy to rise and
// fall and signals done. Assumes the shifter raises busy within a cycle of start.
module disp_write_port
    import disp_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        go_addr,
    input  logic [DATA_W-1:0] go_data,
    input  logic              busy,
    output logic              start,
    output logic [7:0]        addr,
    output logic [DATA_W-1:0] data,
    output logic              done
);

    port_state_t st;

    // Handshake state machine with registered start, payload and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= WP_IDLE;
            start <= 1'b0;
            done  <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else begin
            start <= 1'b0;
            done  <= 1'b0;
            case (st)
                WP_IDLE: if (go) begin
                    start <= 1'b1;
                    addr  <= go_addr;
                    data  <= go_data;
                    st    <= WP_RISE;
                end
                WP_RISE: if (busy) st <= WP_FALL;
                WP_FALL: if (!busy) begin
                    done <= 1'b1;
                    st   <= WP_IDLE;
                end
                default: st <= WP_IDLE;
            endcase
        end
    end

    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    p_no_start_in_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WP_FALL) |-> !start);

    p_done_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/disp_cmd_sequencer.sv
// Display command sequencer. Runs blank/raw-mode/scan/brightness/digits/unblank
// after reset. Refreshes all digits inside a blank/unblank pair on request, and
// optionally issues test-mode on/off writes. One write is outstanding at a time.
module disp_cmd_sequencer
    import disp_seq_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int DATA_W      = 8,
    parameter int INT_W       = 4,
    parameter bit ENABLE_TEST = 1'b1,
    localparam int DIG_W      = $clog2(NUM_DIGITS),
    localparam int FRAME_W    = NUM_DIGITS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               refresh_req,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [INT_W-1:0]   intensity_in,
    input  logic               test_on_req,
    input  logic               test_off_req,
    input  logic               cmd_busy,
    output logic               cmd_start,
    output logic [7:0]         cmd_addr,
    output logic [DATA_W-1:0]  cmd_data
);

    seq_state_t         state;
    step_t              step, nxt_step;
    logic [DIG_W-1:0]   digit, nxt_digit;
    logic               last_step;
    logic               in_init;
    logic [FRAME_W-1:0] frame_buf;
    logic               pend_ref, pend_on, pend_off;
    logic               acc_ref, acc_on, acc_off;
    logic               go, done;
    logic [7:0]         dec_addr;
    logic [DATA_W-1:0]  dec_data;

    assign go      = (state == SQ_ISSUE);
    assign acc_ref = (state == SQ_IDLE) && pend_ref;
    assign acc_on  = (state == SQ_IDLE) && !pend_ref && pend_on;
    assign acc_off = (state == SQ_IDLE) && !pend_ref && !pend_on && pend_off;

    // Hold a refresh request until the sequencer is idle to take it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_ref <= 1'b0;
        else        pend_ref <= (pend_ref && !acc_ref) || refresh_req;
    end

    // Test-mode request latches exist only when the option is built in.
    if (ENABLE_TEST) begin : g_test
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_on  <= 1'b0;
                pend_off <= 1'b0;
            end else begin
                pend_on  <= (pend_on  && !acc_on)  || test_on_req;
                pend_off <= (pend_off && !acc_off) || test_off_req;
            end
        end
    end else begin : g_no_test
        assign pend_on  = 1'b0;
        assign pend_off = 1'b0;
    end

    // Step successor; last_step marks the final write of a sequence.
    always_comb begin
        nxt_step  = step;
        nxt_digit = digit;
        last_step = 1'b0;
        case (step)
            ST_BLANK:  if (in_init) nxt_step = ST_DECODE;
                       else begin nxt_step = ST_DIGIT; nxt_digit = '0; end
            ST_DECODE: nxt_step = ST_SCAN;
            ST_SCAN:   nxt_step = ST_BRIGHT;
            ST_BRIGHT: begin nxt_step = ST_DIGIT; nxt_digit = '0; end
            ST_DIGIT:  if (digit == DIG_W'(NUM_DIGITS - 1)) nxt_step = ST_UNBLANK;
                       else nxt_digit = digit + 1'b1;
            default:   last_step = 1'b1;
        endcase
    end

    // Main sequencer: accept requests at idle, issue, wait, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_ISSUE;
            step      <= ST_BLANK;
            digit     <= '0;
            in_init   <= 1'b1;
            frame_buf <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (acc_ref) begin
                        frame_buf <= frame_in;
                        in_init   <= 1'b0;
                        step      <= ST_BLANK;
                        state     <= SQ_ISSUE;
                    end else if (acc_on) begin
                        step  <= ST_TEST_ON;
                        state <= SQ_ISSUE;
                    end else if (acc_off) begin
                        step  <= ST_TEST_OFF;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: if (done) begin
                    if (last_step) begin
                        state <= SQ_IDLE;
                    end else begin
                        step  <= nxt_step;
                        digit <= nxt_digit;
                        state <= SQ_ISSUE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    disp_step_decode #(
        .NUM_DIGITS (NUM_DIGITS),
        .DATA_W     (DATA_W),
        .INT_W      (INT_W)
    ) u_decode (
        .step   (step),
        .digit  (digit),
        .frame  (frame_buf),
        .bright (intensity_in),
        .addr   (dec_addr),
        .data   (dec_data)
    );

    disp_write_port #(
        .DATA_W (DATA_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_addr (dec_addr),
        .go_data (dec_data),
        .busy    (cmd_busy),
        .start   (cmd_start),
        .addr    (cmd_addr),
        .data    (cmd_data),
        .done    (done)
    );

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (state == SQ_WAIT));

    p_digit_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && step == ST_DIGIT) |->
            (cmd_addr == 8'(digit) + 8'd1) &&
            (cmd_data == frame_buf[digit*DATA_W +: DATA_W]));

    p_unblank_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && step == ST_UNBLANK) |->
            (cmd_addr == A_SHUT) && (cmd_data == DATA_W'(1)));

    p_test_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (ENABLE_TEST || cmd_addr != A_TEST));

endmodule

// File: tb/disp_cmd_sequencer_test.sv
// Bench: two sequencers (test path on and off) share stimulus. Each has a
// shifter model that holds busy for a few cycles after every start, and
// every accepted command is logged for comparison.
module disp_cmd_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_LEN   = 4;
    localparam int LOG_DEPTH  = 256;
    localparam int WATCHDOG   = 100000;

    localparam logic [63:0] FRAMES [4] = '{
        64'h0123_4567_89AB_CDEF,
        64'hFF00_FF00_00FF_00FF,
        64'h8040_2010_0804_0201,
        64'hA5A5_5A5A_C3C3_3C3C
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh_req = 1'b0;
    logic [63:0] frame_in = '0;
    logic [3:0]  intensity_in = 4'hB;
    logic        test_on_req = 1'b0;
    logic        test_off_req = 1'b0;
    logic        busy = 1'b0, busy_nt = 1'b0;
    logic        start, start_nt;
    logic [7:0]  addr, addr_nt, data, data_nt;

    int checks = 0;
    int fails  = 0;
    int log_n  = 0;
    logic [7:0] log_a [LOG_DEPTH];
    logic [7:0] log_d [LOG_DEPTH];
    int busy_cnt = 0, busy_cnt_nt = 0;
    int hs_viol = 0;
    logic prev_start = 1'b0;
    int nt_test_writes = 0;
    int nt_writes = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_cmd_sequencer uut (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .frame_in(frame_in),
        .intensity_in(intensity_in), .test_on_req(test_on_req),
        .test_off_req(test_off_req), .cmd_busy(busy), .cmd_start(start),
        .cmd_addr(addr), .cmd_data(data)
    );

    disp_cmd_sequencer #(.ENABLE_TEST(1'b0)) uut_nt (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .frame_in(frame_in),
        .intensity_in(intensity_in), .test_on_req(test_on_req),
        .test_off_req(test_off_req), .cmd_busy(busy_nt), .cmd_start(start_nt),
        .cmd_addr(addr_nt), .cmd_data(data_nt)
    );

    // Shifter model and command log for the main instance (R7 handshake watch).
    always @(negedge clk) begin
        if (start && (busy || prev_start)) hs_viol <= hs_viol + 1;
        prev_start <= start;
        if (start && !busy) begin
            busy     <= 1'b1;
            busy_cnt <= BUSY_LEN;
            if (log_n < LOG_DEPTH) begin
                log_a[log_n] <= addr;
                log_d[log_n] <= data;
            end
            log_n <= log_n + 1;
        end else if (busy) begin
            if (busy_cnt == 0) busy <= 1'b0;
            else busy_cnt <= busy_cnt - 1;
        end
    end

    // Shifter model for the instance built without the test path.
    always @(negedge clk) begin
        if (start_nt && !busy_nt) begin
            busy_nt     <= 1'b1;
            busy_cnt_nt <= BUSY_LEN;
            nt_writes   <= nt_writes + 1;
            if (addr_nt == 8'h0F) nt_test_writes <= nt_test_writes + 1;
        end else if (busy_nt) begin
            if (busy_cnt_nt == 0) busy_nt <= 1'b0;
            else busy_cnt_nt <= busy_cnt_nt - 1;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    task automatic chk(input int idx, input logic [7:0] ea, input logic [7:0] ed, input string tag);
        checks = checks + 1;
        if (log_a[idx] !== ea || log_d[idx] !== ed) begin
            fails = fails + 1;
            $display("FAIL %s write %0d: got %h/%h expected %h/%h", tag, idx,
                     log_a[idx], log_d[idx], ea, ed);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string tag);
        checks = checks + 1;
        if (got != exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Wait until the log holds target writes, then confirm it stays there.
    task automatic wait_writes(input int target, input string tag);
        int guard = 0;
        while (log_n < target && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        repeat (60) @(posedge clk);
        chk_int(log_n, target, tag);
    endtask

    task automatic wait_first(input int base);
        int guard = 0;
        while (log_n <= base && guard < 1000) begin
            @(posedge clk);
            guard++;
        end
    endtask

    task automatic chk_refresh(input int base, input logic [63:0] f, input string tag);
        chk(base, 8'h0C, 8'h00, tag);
        for (int i = 0; i < 8; i++) chk(base + 1 + i, 8'(i + 1), f[i*8 +: 8], tag);
        chk(base + 9, 8'h0C, 8'h01, tag);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) refresh_req = 1'b1;
        else if (which == 1) test_on_req = 1'b1;
        else test_off_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
        test_on_req = 1'b0;
        test_off_req = 1'b0;
    endtask

    initial begin
        int base;
        frame_in = 64'h1122_3344_5566_7788;
        repeat (4) @(negedge clk);
        chk_int(int'(start), 0, "R1 start low in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R6: request during initialization is held.
        pulse(0);

        wait_writes(23, "R6 init then one refresh");
        chk(0, 8'h0C, 8'h00, "R1");
        chk(1, 8'h09, 8'h00, "R2");
        chk(2, 8'h0B, 8'h07, "R2");
        chk(3, 8'h0A, 8'h0B, "R2");
        for (int i = 0; i < 8; i++) chk(4 + i, 8'(i + 1), 8'h00, "R3");
        chk(12, 8'h0C, 8'h01, "R3");
        chk_refresh(13, 64'h1122_3344_5566_7788, "R6");

        // R4: table of frames.
        for (int v = 0; v < 4; v++) begin
            base = log_n;
            @(negedge clk);
            frame_in = FRAMES[v];
            pulse(0);
            wait_writes(base + 10, "R4 count");
            chk_refresh(base, FRAMES[v], "R4");
        end

        // R5: frame changes after acceptance are not seen.
        base = log_n;
        @(negedge clk);
        frame_in = 64'hDEAD_BEEF_0BAD_F00D;
        pulse(0);
        wait_first(base);
        @(negedge clk);
        frame_in = 64'h0000_0000_0000_0000;
        wait_writes(base + 10, "R5 count");
        chk_refresh(base, 64'hDEAD_BEEF_0BAD_F00D, "R5");

        // R6: several requests during a refresh collapse into one.
        base = log_n;
        @(negedge clk);
        frame_in = 64'h1357_9BDF_2468_ACE0;
        pulse(0);
        wait_first(base);
        @(negedge clk);
        frame_in = 64'h7E7E_8181_7E7E_8181;
        pulse(0);
        pulse(0);
        wait_writes(base + 20, "R6 collapse");
        chk_refresh(base, 64'h1357_9BDF_2468_ACE0, "R6");
        chk_refresh(base + 10, 64'h7E7E_8181_7E7E_8181, "R6");

        // R8: test mode on then off.
        base = log_n;
        pulse(1);
        wait_writes(base + 1, "R8 on count");
        chk(base, 8'h0F, 8'h01, "R8");
        pulse(2);
        wait_writes(base + 2, "R8 off count");
        chk(base + 1, 8'h0F, 8'h00, "R8");

        // R10: refresh before test-on before test-off.
        base = log_n;
        @(negedge clk);
        frame_in = 64'h0F0F_F0F0_3333_CCCC;
        pulse(0);
        wait_first(base);
        pulse(2);
        pulse(1);
        pulse(0);
        wait_writes(base + 22, "R10 count");
        chk_refresh(base, 64'h0F0F_F0F0_3333_CCCC, "R10");
        chk_refresh(base + 10, 64'h0F0F_F0F0_3333_CCCC, "R10");
        chk(base + 20, 8'h0F, 8'h01, "R10");
        chk(base + 21, 8'h0F, 8'h00, "R10");

        // R9: the build without the test path ignored all test requests.
        chk_int(nt_test_writes, 0, "R9 test writes");
        chk_int(nt_writes, log_n - 4, "R9 write count");

        // R7: single-cycle start, never during a busy shift.
        chk_int(hs_viol, 0, "R7 handshake");

        report();
        $finish;
    end

endmodule